// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This controller lets a small processor core read and write an external byte-wide SRAM through a multiplexed pin bus. The low address byte and the data byte share one 8-bit bidirectional bus. The high address byte has its own output lines. An address-latch strobe splits each access in time: the low address is driven while the strobe is high, so that an outside transparent latch follows it. It stays on the bus for one more cycle after the strobe falls. Only then does the bus turn around for data.

The core issues a read or write request with a full address while the controller is idle. Each access takes a fixed sequence of cycles: a latch cycle, a hold cycle, and a read or write strobe of one to four cycles, chosen by a two-bit wait setting. A write then adds one recovery cycle. A one-cycle done pulse ends every access. Address decoding sends only addresses above a parameterised internal boundary to the pins, and only while the external interface is enabled. A bus-keeper option and a float indication describe what the bus does while the controller is not driving it.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, ale is 0, rd_n and wr_n are 1, ad_oe is 0, rsp_done and rsp_err are 0 and busy is 0.
- R2: In the first cycle after a request is accepted, ale is 1, ad_oe is 1, ad_out carries address bits [7:0] and a_hi carries address bits [15:8]. a_hi keeps that value until the next external access is accepted.
- R3: In the second cycle, ale is 0 and ad_out still drives the same low address byte with ad_oe at 1. Both strobes stay high in this cycle.
- R4: The read or write strobe stays low for exactly 1+N consecutive cycles. N is the value of cfg_wait (0 to 3) sampled when the request is accepted. Later changes to cfg_wait do not affect an access already in progress.
- R5: During a read, ad_oe is 0 for as long as rd_n is low. rsp_rdata takes the value on ad_in in the last cycle of the rd_n strobe.
- R6: During a write, ad_out carries the write data with ad_oe at 1 for as long as wr_n is low and for one cycle after wr_n rises. ad_oe then returns to 0.
- R7: rsp_done pulses for one cycle. For a read, the pulse comes in the cycle after the last strobe cycle. For a write, it comes in the cycle after the recovery cycle. busy is 1 from the cycle after acceptance until that done cycle, and is 0 during it.
- R8: Requests presented while busy is 1 are ignored. They cause no extra access and no extra done pulse.
- R9: An address is external when it is greater than INT_TOP (default 16'h025F). A request to an internal address produces no pin activity and no done pulse.
- R10: With cfg_en at 0, a request to an external address produces no pin activity. It produces one cycle of rsp_done together with rsp_err in the following cycle. rsp_err is 0 for every completed external access.
- R11: While cfg_keeper is 1 and ad_oe is 0, ad_keep is 1 and ad_out equals the last value on the bus. That value is the last byte driven, or the last byte sampled by a read.
- R12: With cfg_keeper at 0, ad_float is 1 from the end of a read until the next request of any kind (internal or external) is accepted.
- R13: A request with both req_rd and req_wr high is performed as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | External interface enable |
| cfg_wait | input | 2 | Wait setting N, strobe length 1+N |
| cfg_keeper | input | 1 | Bus keeper enable |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access refused (interface disabled) |
| busy | output | 1 | Access in progress |
| ad_oe | output | 1 | Drive enable for the shared bus |
| ad_out | output | 8 | Value driven on the shared bus |
| ad_in | input | 8 | Value read from the shared bus |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_keep | output | 1 | Keeper holding the bus |
| ad_float | output | 1 | Bus left floating after a read |

## Verification
Several properties are checked on every cycle: the low address stays stable as the latch strobe falls, the bus is released while the read strobe is low, write data stays on the bus across the rising edge of the write strobe, the strobe length matches the captured wait setting, and a done or error pulse never comes while busy. The latch strobe, both strobes, the drive enable, the driven byte, the high address, busy, done, read data, keeper and float flags are all compared with a bench model on every clock. Only the bench's scenarios can show some behaviours: requests ignored while busy, internal and disabled decoding, the read-over-write choice, wait settings changed during an access, and the float flag cleared by an internal request.

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WS_W   = 2,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h025F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              cfg_keeper,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              busy,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ad_keep,
  output logic              ad_float
);
  typedef enum logic [2:0] {S_IDLE, S_ALE, S_HOLD, S_STRB, S_REC} st_e;

  st_e               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, bus_last;
  logic [WS_W-1:0]   wait_q, cnt;
  logic              wr_q, done_q, err_q, float_q;

  wire ext_hit = req_addr > INT_TOP;
  wire addr_ph = (st == S_ALE) || (st == S_HOLD);
  wire data_ph = wr_q && ((st == S_STRB) || (st == S_REC));

  assign ale       = st == S_ALE;
  assign ad_oe     = addr_ph || data_ph;
  assign ad_out    = addr_ph ? addr_q[DATA_W-1:0] : (data_ph ? wdata_q : bus_last);
  assign a_hi      = addr_q[ADDR_W-1:DATA_W];
  assign rd_n      = !((st == S_STRB) && !wr_q);
  assign wr_n      = !((st == S_STRB) && wr_q);
  assign busy      = st != S_IDLE;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign ad_keep   = cfg_keeper && !ad_oe;
  assign ad_float  = float_q && !cfg_keeper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      bus_last <= '0;
      wait_q <= '0;
      cnt <= '0;
      wr_q <= 1'b0;
      done_q <= 1'b0;
      err_q <= 1'b0;
      float_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (ad_oe) bus_last <= ad_out;
      case (st)
        S_IDLE:
          if (req_rd || req_wr) begin
            float_q <= 1'b0;
            if (ext_hit) begin
              if (cfg_en) begin
                st      <= S_ALE;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_wr && !req_rd;
                wait_q  <= cfg_wait;
              end else begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
              end
            end
          end
        S_ALE:  st <= S_HOLD;
        S_HOLD: begin
          st  <= S_STRB;
          cnt <= wait_q;
        end
        S_STRB:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (wr_q) st <= S_REC;
          else begin
            st       <= S_IDLE;
            done_q   <= 1'b1;
            rdata_q  <= ad_in;
            bus_last <= ad_in;
            float_q  <= 1'b1;
          end
        S_REC: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [WS_W:0] slen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slen <= '0;
    else if (!rd_n || !wr_n) slen <= slen + 1'b1;
    else slen <= '0;

  p_ale_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe && $stable(ad_out));
  p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> slen == ({1'b0, wait_q} + 1'b1));
  p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  p_wr_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe && $stable(ad_out));
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !busy);
  p_err_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);
  p_keep_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ad_keep |-> !ad_oe);
endmodule

// File: tb/xmem_bus_ctrl_tb.sv
module xmem_bus_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_keeper = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
  logic [1:0] cfg_wait = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rsp_rdata, ad_out, ad_in, a_hi;
  logic rsp_done, rsp_err, busy, ad_oe, ale, rd_n, wr_n, ad_keep, ad_float;

  always #10 clk = ~clk;

  xmem_bus_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wait(cfg_wait),
    .cfg_keeper(cfg_keeper), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .busy(busy), .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .ad_keep(ad_keep), .ad_float(ad_float));

  // outside latch and memory: data depends on latched address and strobe cycle
  logic [15:0] lat = '0;
  logic [7:0] rdcnt = '0;
  always @* if (ale) lat = {a_hi, ad_out};
  always @(posedge clk) rdcnt <= !rd_n ? rdcnt + 8'd1 : 8'd0;
  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ad_in = !rd_n ? (memf(lat) ^ rdcnt) : ad_out;

  int total = 0, fails = 0;
  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: phase counter of the current access
  int ph = -1, m_n = 0;
  logic m_wr = 0, m_done = 0, m_err = 0, m_float = 0;
  logic [15:0] m_addr = '0;
  logic [7:0] m_wd = '0, m_rdata = '0, m_last = '0;
  function automatic logic e_oe();
    return ph == 0 || ph == 1 || (m_wr && ph >= 2);
  endfunction
  function automatic logic [7:0] e_out();
    if (ph == 0 || ph == 1) return m_addr[7:0];
    if (m_wr && ph >= 2) return m_wd;
    return m_last;
  endfunction
  function automatic logic e_strb();
    return ph >= 2 && ph <= m_n + 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = -1; m_wr = 0; m_done = 0; m_err = 0; m_float = 0;
      m_addr = '0; m_wd = '0; m_rdata = '0; m_last = '0;
    end else begin
      if (e_oe()) m_last = e_out();
      m_done = 0; m_err = 0;
      if (ph < 0) begin
        if (req_rd || req_wr) begin
          m_float = 0;
          if (req_addr > 16'h025F) begin
            if (cfg_en) begin
              ph = 0; m_addr = req_addr; m_wd = req_wdata;
              m_wr = req_wr && !req_rd; m_n = cfg_wait;
            end else begin m_done = 1; m_err = 1; end
          end
        end
      end else begin
        ph++;
        if (ph == (m_wr ? m_n + 4 : m_n + 3)) begin
          ph = -1; m_done = 1;
          if (!m_wr) begin
            m_rdata = memf(m_addr) ^ 8'(m_n);
            m_last = m_rdata; m_float = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(ale, ph == 0, "R2/R3/R9/R10 ale");
    chk(ad_oe, e_oe(), "R2/R5/R6 ad_oe");
    if (e_oe() || cfg_keeper) chk(ad_out, e_out(), "R2/R3/R6/R11 ad_out");
    chk(a_hi, m_addr[15:8], "R2 a_hi");
    chk(rd_n, !(e_strb() && !m_wr), "R4/R5/R13 rd_n");
    chk(wr_n, !(e_strb() && m_wr), "R4/R6/R13 wr_n");
    chk(busy, ph >= 0, "R7/R8 busy");
    chk(rsp_done, m_done, "R7/R8/R10 done");
    chk(rsp_err, m_err, "R10 err");
    if (m_done && !m_err) chk(rsp_rdata, m_rdata, "R5 rdata");
    chk(ad_keep, cfg_keeper && !e_oe(), "R11 keep");
    chk(ad_float, m_float && !cfg_keeper, "R12 float");
  end

  task automatic acc(input logic rd, input logic wr, input logic [15:0] a,
                     input logic [7:0] d, input logic [1:0] n);
    @(negedge clk);
    cfg_wait = n; req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_rd = 0; req_wr = 0; cfg_wait = ~n;
    repeat (9) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        fails++; total++;
        $display("FAIL watchdog R7 actual=hung expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({ale, rd_n, wr_n, ad_oe, rsp_done, rsp_err, busy}, 7'b0110000, "R1 reset");
    cfg_en = 1;
    acc(0, 1, 16'h1234, 8'hA5, 0);
    acc(1, 0, 16'h1234, 8'h00, 0);
    acc(1, 0, 16'h8001, 8'h00, 3);
    acc(0, 1, 16'hFFFF, 8'h3C, 2);
    acc(1, 0, 16'hFFFF, 8'h00, 1);
    acc(1, 0, 16'h025F, 8'h00, 0);   // R9 internal boundary, clears float (R12)
    acc(1, 0, 16'h0260, 8'h00, 2);   // R9 first external address
    // R8: request during busy ignored
    @(negedge clk); cfg_wait = 3; req_rd = 1; req_addr = 16'h4444;
    @(negedge clk); req_rd = 0;
    @(negedge clk); req_wr = 1; req_addr = 16'h7777; req_wdata = 8'h99;
    @(negedge clk); req_wr = 0;
    repeat (10) @(negedge clk);
    acc(1, 1, 16'h5AA5, 8'h11, 1);   // R13
    cfg_keeper = 1;                  // R11
    acc(1, 0, 16'h9ABC, 8'h00, 0);
    acc(0, 1, 16'h9ABC, 8'hE7, 3);
    cfg_keeper = 0;
    cfg_en = 0;                      // R10
    acc(1, 0, 16'hC000, 8'h00, 0);
    acc(0, 1, 16'h0010, 8'h22, 0);
    cfg_en = 1;
    acc(1, 0, 16'h0300, 8'h00, 3);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule